// File: doc/BRIEF.md
# Word-Oriented SPI Flash Master

This block is a serial peripheral master for one flash device, controlled through a small 32-bit register window. Software fills a four-entry transmit queue with words, writes a control word that selects the transfer length (1 to 32 bits), the clock idle level, the sampling phase and the direction enables, and sets a start bit. The engine then pops one word, shifts it out most significant bit first while it captures the input line, and places the captured bits, right-justified, into a four-entry receive queue.

The chip-select line is active low and is owned by software. While the software-select bit is set, a 1 in the select-value bit pulls the pin low. This lets one select window cover several words, for example a command byte followed by a data read. A status word shows the engine's busy state, a completion flag, queue fill state, and sticky error flags. Each sticky flag is cleared by writing 1 to its position.

Top module: `spi_word_master`

## Requirements
- R1: After reset, the control word reads 0 and the status word reads 0x02800000 (receive empty bit 25, transmit empty bit 23). The select pin is high and the serial clock is low.
- R2: Control bits 4:0 hold the length minus one. Bit (length-1) of the transmit word is driven first, and the bits follow in falling order.
- R3: The received bits are stored right-justified in the receive queue, which is read at offset 0x20. A word is stored only when receive enable (control bit 14) was set at start. Status bit 24 shows a full receive queue.
- R4: A nonzero control field 27:26 makes the clock idle high. A nonzero field 19:18 moves sampling to the trailing clock edge, and a zero field samples on the leading edge. The device sees correct data in all four combinations.
- R5: With control bit 12 set, the select pin equals the inverse of control bit 13.
- R6: Status bit 31 is high from the accepted start until the word completes. Completion sets sticky status bit 30. Writing 1 to bit 30 clears it, and writing 0 leaves it set.
- R7: The transmit queue, written at offset 0x10, holds 4 words and shows full on status bit 22. A write to a full queue is dropped and sets sticky bit 26.
- R8: A read of an empty receive queue returns 0 and sets sticky bit 27. Writing 1 to bit 27 clears it, and writing 0 leaves it set.
- R9: The start bit (control bit 30) always reads 0. A start is ignored while busy or while the transmit queue is empty.
- R10: With transmit enable (control bit 15) clear, the output data line is held at 0 for every bit of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at 0x20) |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 1 | Device select, active low |

## Verification
The hardest condition to reach is a start request that arrives while a word is still shifting and another word is already waiting in the transmit queue. If the request were wrongly accepted, it would cut the first word short and pop the second. The stimulus loads two words and writes the start bit twice in back-to-back bus cycles. It then shows that exactly one word appeared on the line and that the queue still holds the other. Reaching both queue limits also needs a burst of five writes before any start, followed by four transfers with no reads in between, so the receive queue fills before it is drained past empty.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
   localparam int unsigned REG_W = 32;

   // register byte offsets
   localparam int unsigned OFF_CTRL = 'h00;
   localparam int unsigned OFF_STAT = 'h04;
   localparam int unsigned OFF_TXQ  = 'h10;
   localparam int unsigned OFF_RXQ  = 'h20;

   // control word bit positions
   localparam int unsigned CB_START  = 30;
   localparam int unsigned CB_POL_LO = 26;
   localparam int unsigned CB_POL_HI = 27;
   localparam int unsigned CB_PHA_LO = 18;
   localparam int unsigned CB_PHA_HI = 19;
   localparam int unsigned CB_TXON   = 15;
   localparam int unsigned CB_RXON   = 14;
   localparam int unsigned CB_SELV   = 13;
   localparam int unsigned CB_SELSW  = 12;

   // status word bit positions
   localparam int unsigned SB_BUSY  = 31;
   localparam int unsigned SB_DONE  = 30;
   localparam int unsigned SB_UNDR  = 27;
   localparam int unsigned SB_OVFL  = 26;
   localparam int unsigned SB_RXE   = 25;
   localparam int unsigned SB_RXF   = 24;
   localparam int unsigned SB_TXE   = 23;
   localparam int unsigned SB_TXF   = 22;

   localparam logic [REG_W-1:0] CTRL_KEEP = 32'h0C0C_F01F;
endpackage

// File: rtl/spi_wm_fifo.sv
module spi_wm_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_wm_fifo: DEPTH must be at least 2");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("spi_wm_fifo: DEPTH must be a power of two");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [CW-1:0]    cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign rdata = mem[rp];

   always_ff @(posedge clk) begin
      if (push && !full) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push && !full) wp <= wp + 1'b1;
         if (pop && !empty) rp <= rp + 1'b1;
         case ({push && !full, pop && !empty})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // the owner must gate its requests with the flags
   p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
endmodule

// File: rtl/spi_wm_engine.sv
module spi_wm_engine #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned HALF_DIV = 2,
   parameter int unsigned LEN_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_word,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic              cpha,
   input  logic              cpol,
   input  logic              tx_en,
   input  logic              miso,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_word,
   output logic              sclk,
   output logic              mosi
);
   localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(DATA_W - 1);

   if ((DATA_W & (DATA_W - 1)) != 0 || DATA_W < 2) begin : g_bad_width
      $error("spi_wm_engine: DATA_W must be a power of two");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("spi_wm_engine: HALF_DIV must be at least 1");
   end

   logic              tick;
   logic              phase;   // 1 between a leading and a trailing edge
   logic              first;
   logic              pha_q;
   logic [LEN_W-1:0]  bits_left;
   logic [DATA_W-1:0] sreg, rreg;

   if (HALF_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
   end else begin : g_div
      localparam int unsigned DW = $clog2(HALF_DIV);
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          dcnt <= '0;
         else if (start || !busy)             dcnt <= '0;
         else if (dcnt == DW'(HALF_DIV - 1))  dcnt <= '0;
         else                                 dcnt <= dcnt + 1'b1;
      end
      assign tick = (dcnt == DW'(HALF_DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         phase     <= 1'b0;
         first     <= 1'b0;
         pha_q     <= 1'b0;
         bits_left <= '0;
         sreg      <= '0;
         rreg      <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy      <= 1'b1;
            phase     <= 1'b0;
            first     <= 1'b1;
            pha_q     <= cpha;
            bits_left <= len_m1;
            sreg      <= tx_en ? (tx_word << (TOP_IDX - len_m1)) : '0;
            rreg      <= '0;
         end else if (busy && tick) begin
            if (!phase) begin
               // leading edge
               phase <= 1'b1;
               first <= 1'b0;
               if (!pha_q)      rreg <= {rreg[DATA_W-2:0], miso};
               else if (!first) sreg <= sreg << 1;
            end else begin
               // trailing edge
               phase <= 1'b0;
               if (pha_q) rreg <= {rreg[DATA_W-2:0], miso};
               if (bits_left == '0) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bits_left <= bits_left - LEN_W'(1);
                  if (!pha_q) sreg <= sreg << 1;
               end
            end
         end
      end
   end

   assign sclk    = cpol ^ phase;
   assign mosi    = sreg[DATA_W-1];
   assign rx_word = rreg;

   p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == cpol));
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
   import spi_wm_pkg::*;
#(
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter int unsigned HALF_DIV   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n
);
   localparam int unsigned LEN_W = $clog2(REG_W);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("spi_word_master: ADDR_W must reach offset 0x20");
   end

   logic [REG_W-1:0] ctrl_q, ctrl_nx;
   logic             st_done, st_undr, st_ovfl;
   logic             rx_on_q;

   logic             sel_ctrl, sel_stat, sel_txq, sel_rxq;
   logic             start, eng_busy, eng_done;
   logic [REG_W-1:0] eng_rx, txq_head, rxq_head;
   logic             txq_empty, txq_full, rxq_empty, rxq_full;
   logic             txq_push, rxq_push, rxq_pop;

   assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
   assign sel_stat = (bus_addr == ADDR_W'(OFF_STAT));
   assign sel_txq  = (bus_addr == ADDR_W'(OFF_TXQ));
   assign sel_rxq  = (bus_addr == ADDR_W'(OFF_RXQ));

   assign ctrl_nx  = (bus_wr && sel_ctrl) ? (bus_wdata & CTRL_KEEP) : ctrl_q;
   assign start    = bus_wr && sel_ctrl && bus_wdata[CB_START] && !eng_busy && !txq_empty;
   assign txq_push = bus_wr && sel_txq && !txq_full;
   assign rxq_push = eng_done && rx_on_q && !rxq_full;
   assign rxq_pop  = bus_rd && sel_rxq && !rxq_empty;

   spi_wm_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) i_txq (
      .clk(clk), .rst_n(rst_n),
      .push(txq_push), .wdata(bus_wdata),
      .pop(start), .rdata(txq_head),
      .empty(txq_empty), .full(txq_full));

   spi_wm_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) i_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rxq_push), .wdata(eng_rx),
      .pop(rxq_pop), .rdata(rxq_head),
      .empty(rxq_empty), .full(rxq_full));

   spi_wm_engine #(.DATA_W(REG_W), .HALF_DIV(HALF_DIV), .LEN_W(LEN_W)) i_engine (
      .clk(clk), .rst_n(rst_n),
      .start(start),
      .tx_word(txq_head),
      .len_m1(ctrl_nx[LEN_W-1:0]),
      .cpha(|ctrl_nx[CB_PHA_HI:CB_PHA_LO]),
      .cpol(|ctrl_q[CB_POL_HI:CB_POL_LO]),
      .tx_en(ctrl_nx[CB_TXON]),
      .miso(spi_miso),
      .busy(eng_busy), .done(eng_done),
      .rx_word(eng_rx),
      .sclk(spi_sclk), .mosi(spi_mosi));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         rx_on_q <= 1'b0;
         st_done <= 1'b0;
         st_undr <= 1'b0;
         st_ovfl <= 1'b0;
      end else begin
         ctrl_q <= ctrl_nx;
         if (start) rx_on_q <= ctrl_nx[CB_RXON];
         // a set event wins over a clearing write in the same cycle
         st_done <= eng_done | (st_done & ~(bus_wr && sel_stat && bus_wdata[SB_DONE]));
         st_undr <= (bus_rd && sel_rxq && rxq_empty)
                    | (st_undr & ~(bus_wr && sel_stat && bus_wdata[SB_UNDR]));
         st_ovfl <= (bus_wr && sel_txq && txq_full)
                    | (st_ovfl & ~(bus_wr && sel_stat && bus_wdata[SB_OVFL]));
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_ctrl)      bus_rdata = ctrl_q;
      else if (sel_stat) bus_rdata = {eng_busy, st_done, 2'b00, st_undr, st_ovfl,
                                      rxq_empty, rxq_full, txq_empty, txq_full, 22'd0};
      else if (sel_rxq)  bus_rdata = rxq_empty ? '0 : rxq_head;
   end

   assign spi_cs_n = ctrl_q[CB_SELSW] ? ~ctrl_q[CB_SELV] : ~eng_busy;

   p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eng_busy) |=> st_done);
   p_ovfl_on_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_txq && txq_full) |=> st_ovfl);
   p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel_rxq && rxq_empty) |-> (bus_rdata == '0));
   p_start_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ctrl |-> !bus_rdata[CB_START]);
endmodule

// File: tb/test_spi_word_master.sv
module test_spi_word_master;
   localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_TXQ = 6'h10, A_RXQ = 6'h20;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic spi_sclk, spi_mosi, spi_miso, spi_cs_n;
   bit   inv_miso = 1'b0;

   int checks = 0, fails = 0;
   logic [31:0] exp_q[$];
   int   m_len = 8;
   bit   m_cpol = 1'b0, m_cpha = 1'b0;
   logic [31:0] cap = '0;
   int   nb = 0;

   always #10 clk = ~clk;
   assign spi_miso = inv_miso ? ~spi_mosi : spi_mosi;

   spi_word_master i_spi_word_master (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: capture the device-side sampled bits and compare with the scoreboard
   always @(spi_sclk) begin
      if (rst_n && !spi_cs_n && spi_sclk == (m_cpol ^ ~m_cpha)) begin
         cap = {cap[30:0], spi_mosi};
         nb++;
         if (nb == m_len) begin
            if (exp_q.size() == 0) chk(1'b0, "R2 unexpected word", cap, 32'h0);
            else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               chk(cap == e, "R2/R4/R10 line word", cap, e);
            end
            nb  = 0;
            cap = '0;
         end
      end
   end

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 2000; i++) begin
         rd(A_STAT, s);
         if (!s[31]) return;
      end
      chk(1'b0, "R6 busy never cleared", s, 32'h0);
   endtask

   function automatic logic [31:0] mask_of(input int len);
      logic [63:0] m;
      m = (64'd1 << len) - 64'd1;
      return m[31:0];
   endfunction

   function automatic logic [31:0] cfg_of(input int len, input bit pol, input bit pha,
                                          input bit txon, input bit rxon);
      return 32'(len - 1) | (32'(pha) << 18) | (32'(pol) << 26) | (32'(txon) << 15)
             | (32'(rxon) << 14) | (32'd1 << 12);
   endfunction

   task automatic xfer(input logic [31:0] w, input int len, input bit pol, input bit pha,
                       input bit inv, input bit rxon, input bit txon);
      logic [31:0] cfg, s, r, line, exp_rx;
      m_cpol = pol; m_cpha = pha; m_len = len; inv_miso = inv;
      cfg = cfg_of(len, pol, pha, txon, rxon);
      wr(A_CTRL, cfg);
      chk(spi_sclk == pol, "R4 idle clock level", 32'(spi_sclk), 32'(pol));
      wr(A_CTRL, cfg | (32'd1 << 13));
      chk(spi_cs_n == 1'b0, "R5 select asserted", 32'(spi_cs_n), 32'd0);
      wr(A_TXQ, w);
      line = txon ? (w & mask_of(len)) : 32'h0;
      exp_q.push_back(line);
      wr(A_CTRL, cfg | (32'd1 << 13) | (32'd1 << 30));
      rd(A_STAT, s);
      chk(s[31] == 1'b1, "R6 busy after start", s, 32'h8000_0000);
      wait_idle();
      rd(A_STAT, s);
      chk(s[30] == 1'b1, "R6 done flag set", s, 32'h4000_0000);
      exp_rx = inv ? (~line & mask_of(len)) : line;
      if (rxon) begin
         rd(A_RXQ, r);
         chk(r == exp_rx, "R3 received word", r, exp_rx);
      end else begin
         rd(A_STAT, s);
         chk(s[25] == 1'b1, "R3 receive disabled stores nothing", s, 32'h0200_0000);
      end
      wr(A_STAT, 32'h0);
      rd(A_STAT, s);
      chk(s[30] == 1'b1, "R6 zero write keeps done", s, 32'h4000_0000);
      wr(A_STAT, 32'h4000_0000);
      rd(A_STAT, s);
      chk(s[30] == 1'b0, "R6 done cleared", s, 32'h0);
      wr(A_CTRL, cfg);
      chk(spi_cs_n == 1'b1, "R5 select released", 32'(spi_cs_n), 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] s, r, cfg;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(A_CTRL, r);
      chk(r == 32'h0, "R1 control reset", r, 32'h0);
      rd(A_STAT, s);
      chk(s == 32'h0280_0000, "R1 status reset", s, 32'h0280_0000);
      chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 pins idle",
          {30'd0, spi_cs_n, spi_sclk}, 32'h2);

      // R2/R3/R4 across modes and lengths
      xfer(32'h0000_00A5, 8,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      xfer(32'h1234_5678, 32, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      xfer(32'hFFFF_FFF5, 3,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
      xfer(32'h0000_0001, 1,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
      xfer(32'h0002_C3A7, 18, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      // R3 receive disabled
      xfer(32'h0000_3C5A, 16, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      // R10 transmit disabled, inverted loopback shows all ones received
      xfer(32'h0000_00FF, 8,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0);

      // R7 queue overflow, R3 receive full, R8 underrun
      m_cpol = 1'b0; m_cpha = 1'b0; m_len = 8; inv_miso = 1'b0;
      cfg = cfg_of(8, 1'b0, 1'b0, 1'b1, 1'b1) | (32'd1 << 13);
      wr(A_CTRL, cfg);
      for (int i = 1; i <= 5; i++) wr(A_TXQ, 32'(i * 'h11));
      rd(A_STAT, s);
      chk(s[22] && s[26], "R7 full and overflow", s, 32'h0440_0000);
      for (int i = 1; i <= 4; i++) exp_q.push_back(32'(i * 'h11));
      for (int i = 0; i < 4; i++) begin
         wr(A_CTRL, cfg | (32'd1 << 30));
         wait_idle();
      end
      rd(A_STAT, s);
      chk(s[24] && s[23], "R3 receive full, R7 fifth word dropped", s, 32'h0180_0000);
      for (int i = 1; i <= 4; i++) begin
         rd(A_RXQ, r);
         chk(r == 32'(i * 'h11), "R3 queued receive order", r, 32'(i * 'h11));
      end
      rd(A_RXQ, r);
      chk(r == 32'h0, "R8 empty read returns zero", r, 32'h0);
      wr(A_STAT, 32'h0);
      rd(A_STAT, s);
      chk(s[27] && s[26], "R8 R7 zero write keeps flags", s, 32'h0C00_0000);
      wr(A_STAT, 32'h4C00_0000);
      rd(A_STAT, s);
      chk(!s[27] && !s[26] && !s[30], "R8 R7 flags cleared", s, 32'h0);

      // R9 start with empty queue
      wr(A_CTRL, cfg | (32'd1 << 30));
      repeat (3) @(negedge clk);
      rd(A_STAT, s);
      chk(!s[31] && !s[30], "R9 start ignored on empty queue", s, 32'h0);
      rd(A_CTRL, r);
      chk(r == cfg, "R9 start reads zero", r, cfg);

      // R9 start while busy
      wr(A_TXQ, 32'h66);
      wr(A_TXQ, 32'h77);
      exp_q.push_back(32'h66);
      wr(A_CTRL, cfg | (32'd1 << 30));
      wr(A_CTRL, cfg | (32'd1 << 30));
      wait_idle();
      repeat (20) @(negedge clk);
      rd(A_STAT, s);
      chk(!s[31] && !s[23], "R9 second start ignored, word left queued", s, 32'h0);
      chk(exp_q.size() == 0, "R9 one word on the line", 32'(exp_q.size()), 32'd0);
      exp_q.push_back(32'h77);
      wr(A_CTRL, cfg | (32'd1 << 30));
      wait_idle();
      rd(A_RXQ, r);
      chk(r == 32'h66, "R9 first received", r, 32'h66);
      rd(A_RXQ, r);
      chk(r == 32'h77, "R9 second received", r, 32'h77);
      wr(A_CTRL, cfg & ~(32'd1 << 13));
      chk(exp_q.size() == 0, "R2 scoreboard drained", 32'(exp_q.size()), 32'd0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule